// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from the system clock. A programmable prescaler divides the system clock into module-clock ticks. Two phase counters then time the low and high halves of SCL. Each half lasts its programmed count plus a fixed extra number of module ticks, called d. The value of d depends on the prescaler setting, or it is forced to 6 by a build-time parameter. Because the low and high counts are separate, SCL can have an asymmetric duty cycle, for example a high time half as long as the low time.

The bit engine starts and stops the generator with a run request. While run is low, the generator is idle, SCL is released, and the three divider settings are captured. While run is high, the captured settings are used and changes on the divider inputs have no effect.

The SCL output is open-drain style: a drive-low request. The block also emits one-cycle strobes at each SCL rising and falling edge for the data path. During the high phase, counting advances only while the sensed SCL line is high, so a slave can stretch the clock. A high count of zero disables clock generation completely.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, scl_drive_low, scl_rise and scl_fall are all 0.
- R2: While run is 0, SCL is released (scl_drive_low=0) from the next cycle on. presc, low_cnt and high_cnt are captured only while run is 0. Changing them while run is 1 does not alter the running waveform.
- R3: When run goes to 1 with a nonzero captured high count, the next clock edge pulls SCL low and pulses scl_fall. The low phase always comes first.
- R4: The low phase lasts (low_cnt + d) * (presc + 1) system clock cycles.
- R5: Without stretching, the high phase lasts (high_cnt + d) * (presc + 1) system clock cycles.
- R6: With FIXED_D6=0, d is 7 for presc=0, 6 for presc=1, and 5 for presc of 2 or more.
- R7: With FIXED_D6=1, d is 6 for every presc value.
- R8: If the captured high count is 0, SCL is never driven low and no strobe is produced while run is 1.
- R9: During the high phase, the prescaler and the phase counter hold while scl_in reads 0. A stretch of N cycles lengthens the high phase by exactly N cycles.
- R10: scl_rise and scl_fall are one-cycle pulses that never occur together. Each coincides with the cycle in which scl_drive_low falls or rises. Stopping the generator during a low phase releases SCL and pulses scl_rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Run request from the bit engine; 0 holds the generator idle and captures settings |
| presc | input | W | Prescaler value; module tick every presc+1 cycles |
| low_cnt | input | W | Low-phase count |
| high_cnt | input | W | High-phase count; 0 disables the clock |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-cycle strobe at SCL release |
| scl_fall | output | 1 | One-cycle strobe at SCL pull-down |

## Verification
Clock stretching is the hardest case to reach. The bench models the SCL line as the wired-AND of the block's release and an external stretch request. It raises that request in the first cycle of a high phase and holds it for a fixed number of cycles. It then checks that the high time grows by exactly that amount. The second hard case is the requirement that settings are ignored while running. The bench rewrites the low count in the middle of a run and measures the next full low phase, which must be unchanged.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int W = 16,
  parameter bit FIXED_D6 = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] presc,
  input  logic [W-1:0] low_cnt,
  input  logic [W-1:0] high_cnt,
  input  logic         scl_in,
  output logic         scl_drive_low,
  output logic         scl_rise,
  output logic         scl_fall
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t          st;
  logic [W-1:0] p_r, l_r, h_r, pcnt;
  logic [W:0]   ph, phase_len;
  logic [2:0]   extra;
  logic         gate, tick, last;

  generate
    if (FIXED_D6) begin : g_fixed
      assign extra = 3'd6;
    end else begin : g_scaled
      assign extra = (p_r == '0) ? 3'd7 : (p_r == W'(1)) ? 3'd6 : 3'd5;
    end
  endgenerate

  assign phase_len = {1'b0, (st == S_HIGH) ? h_r : l_r} + (W+1)'(extra);
  assign gate = (st == S_LOW) || (st == S_HIGH && scl_in);
  assign tick = gate && (pcnt == p_r);
  assign last = tick && (ph == phase_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; p_r <= '0; l_r <= '0; h_r <= '0;
      pcnt <= '0; ph <= '0;
      scl_drive_low <= 1'b0; scl_rise <= 1'b0; scl_fall <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (!run) begin
        p_r <= presc; l_r <= low_cnt; h_r <= high_cnt;
        pcnt <= '0; ph <= '0; st <= S_IDLE;
        scl_drive_low <= 1'b0;
        if (st == S_LOW) scl_rise <= 1'b1;
      end else if (st == S_IDLE) begin
        if (h_r != '0) begin
          st <= S_LOW; scl_drive_low <= 1'b1; scl_fall <= 1'b1;
        end
      end else if (gate) begin
        if (tick) begin
          pcnt <= '0;
          if (last) begin
            ph <= '0;
            st <= (st == S_LOW) ? S_HIGH : S_LOW;
            scl_drive_low <= (st == S_HIGH);
            scl_rise <= (st == S_LOW);
            scl_fall <= (st == S_HIGH);
          end else begin
            ph <= ph + 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !scl_drive_low); // R2
  AST_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_drive_low) |-> scl_fall); // R3
  AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_drive_low) |-> scl_rise); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(scl_rise && scl_fall)); // R10
  AST_ZERO_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (h_r == '0) |-> !scl_drive_low); // R8
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (run && st == S_HIGH && !scl_in) |=> ($stable(ph) && $stable(pcnt))); // R9
endmodule

// File: tb/test_scl_clock_gen.sv
`timescale 1ns/1ps
module test_scl_clock_gen;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, stretch = 1'b0;
  logic [W-1:0] presc = '0, low_cnt = '0, high_cnt = '0;
  logic dl_a, ri_a, fa_a, dl_b, ri_b, fa_b;
  logic sin_a, sin_b;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign sin_a = !dl_a && !stretch;
  assign sin_b = !dl_b;

  scl_clock_gen #(.W(W), .FIXED_D6(1'b0)) i_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(presc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(sin_a), .scl_drive_low(dl_a),
    .scl_rise(ri_a), .scl_fall(fa_a));

  scl_clock_gen #(.W(W), .FIXED_D6(1'b1)) i_scl_clock_gen_fix (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(presc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(sin_b), .scl_drive_low(dl_b),
    .scl_rise(ri_b), .scl_fall(fa_b));

  // presc, low, high, low cycles, high cycles, fixed-d low, fixed-d high
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{0, 3, 2, 10,  9,  9,  8},
    '{1, 2, 1, 16, 14, 16, 14},
    '{2, 0, 4, 15, 27, 18, 30},
    '{3, 6, 1, 44, 24, 48, 28},
    '{0, 0, 1,  7,  8,  6,  7}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic drv(input bit sel);
    return sel ? dl_b : dl_a;
  endfunction

  function automatic logic fal(input bit sel);
    return sel ? fa_b : fa_a;
  endfunction

  task automatic measure(input bit sel, output int lo, output int hi);
    int guard = 0;
    lo = 0; hi = 0;
    do begin @(negedge clk); guard++; end while (!fal(sel) && guard < 5000);
    while (drv(sel) && lo < 5000) begin lo++; @(negedge clk); end
    while (!drv(sel) && hi < 5000) begin hi++; @(negedge clk); end
  endtask

  task automatic setup(input int p, input int l, input int h);
    @(negedge clk); run = 1'b0;
    presc = W'(p); low_cnt = W'(l); high_cnt = W'(h);
    repeat (2) @(negedge clk);
    run = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, cnt;
    repeat (3) @(negedge clk);
    chk("R1 drive", int'(dl_a), 0);
    chk("R1 strobes", int'(ri_a | fa_a), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2]);
      @(negedge clk);
      chk("R3 low first with fall strobe", int'({dl_a, fa_a}), 3);
      measure(1'b0, lo, hi);
      chk("R4/R6 low duration", lo, VEC[i][3]);
      chk("R5/R6 high duration", hi, VEC[i][4]);
      measure(1'b1, lo, hi);
      chk("R7 fixed d low", lo, VEC[i][5]);
      chk("R7 fixed d high", hi, VEC[i][6]);
    end

    // R2: settings changed while running are ignored
    setup(0, 3, 2);
    measure(1'b0, lo, hi);
    low_cnt = W'(20);
    measure(1'b0, lo, hi);
    chk("R2 low unchanged while running", lo, 10);
    run = 1'b0;
    @(negedge clk);
    chk("R2 released when stopped", int'(dl_a), 0);

    // R8: zero high count produces nothing
    setup(1, 3, 0);
    cnt = 0;
    repeat (200) begin
      @(negedge clk);
      if (dl_a || ri_a || fa_a) cnt++;
    end
    chk("R8 no activity with zero high count", cnt, 0);

    // R9: stretch of 5 cycles at start of high phase
    setup(0, 1, 1);
    do @(negedge clk); while (!fa_a);
    while (dl_a) @(negedge clk);
    stretch = 1'b1;
    hi = 0;
    for (int k = 0; k < 5; k++) begin hi++; @(negedge clk); end
    stretch = 1'b0;
    while (!dl_a && hi < 5000) begin hi++; @(negedge clk); end
    chk("R9 stretched high duration", hi, 13);

    // R10: stop during low phase releases SCL with a rise strobe
    setup(0, 10, 2);
    do @(negedge clk); while (!fa_a);
    repeat (3) @(negedge clk);
    chk("R10 still low before stop", int'(dl_a), 1);
    run = 1'b0;
    @(negedge clk);
    chk("R10 rise strobe on stop", int'({dl_a, ri_a, fa_a}), 2);
    @(negedge clk);
    chk("R10 strobe lasts one cycle", int'(ri_a), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule